// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block sits on the host side of a single-lane SPI link to a 64-Mbit serial NOR flash. It turns one user request into the complete series of SPI frames that the request needs. A request is made of an operation code, a 24-bit byte address and a byte count. The supported requests are normal read, fast read, page program, three erase sizes, whole-chip erase, identification read and device reset. Program data enters through a byte-wide valid/ready handshake. Read data leaves as one-cycle strobes.

Program and erase requests run as a fixed series of frames. First comes a write-enable frame, then the command frame, then status-read frames repeated until the busy flag clears. A program request longer than the space left in its 256-byte page is split. The split pieces are issued as separate, page-aligned program commands, and each piece gets its own write-enable and its own polling. Reset is sent as two single-byte frames. The serial clock runs in SPI mode 0, MSB first, at a rate set by a run-time divider. Chip select always stays high for a minimum number of system clocks between frames.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset and whenever `req_ready` is high, `spi_cs_n` is 1 and `spi_sclk` is 0. `req_ready` is high once reset ends.
- R2: Transfers use SPI mode 0 with bytes sent MSB first. The clock idles low, `spi_mosi` is stable while `spi_sclk` is high, and `spi_miso` is sampled on the rising edge. Each high phase and each low phase of `spi_sclk` lasts `cfg_div`+1 system clocks.
- R3: `req_op`=0 (read) sends one frame: 03h, then three address bytes (bits 23:16, 15:8, 7:0), then `req_len` bytes clocked in. Each clocked-in byte appears in order on `rd_data` with a one-cycle `rd_valid`.
- R4: `req_op`=1 (fast read) sends one frame: 0Bh, three address bytes, one dummy byte, then `req_len` data bytes delivered as in R3.
- R5: `req_op`=2 (program) puts a separate single-byte 06h frame before every 02h frame. Chip select goes high between the two frames.
- R6: No 02h frame crosses a 256-byte page. The first piece carries min(`req_len`, 256 − address[7:0]) bytes, and later pieces start on page boundaries. Data bytes are taken in order, one per `wr_valid`&&`wr_ready` cycle.
- R7: After each program or erase frame, single-status frames (05h plus one byte in) are repeated until bit 0 of the returned byte is 0. `done` then pulses for exactly one cycle.
- R8: `req_op` 3, 4 and 5 send 06h and then 20h, 52h or D8h followed by three address bytes. `req_op`=6 sends 06h and then the single byte C7h with no address.
- R9: `req_op`=7 sends 9Fh and returns the three identification bytes through `rd_data`.
- R10: `req_op`=8 sends two single-byte frames, 66h and then 99h, followed by `done`.
- R11: Chip select stays high for at least `CS_GAP` system clocks before every falling edge.
- R12: `req_op` values 9 to 15 produce no frame. `spi_cs_n` stays high and `done` pulses within two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | SPI clock half-period minus one, in system clocks |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is high |
| req_op | input | 4 | Operation code (see R3 to R12) |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Byte count for read and program (at least 1) |
| req_ready | output | 1 | Sequencer idle, accepting a request |
| done | output | 1 | One-cycle pulse when a request completes |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte available |
| wr_ready | output | 1 | Sequencer takes `wr_data` this cycle if `wr_valid` |
| rd_data | output | 8 | Data byte returned by read or identification |
| rd_valid | output | 1 | `rd_data` valid strobe |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A wrong phase or a wrong page-offset calculation shows up at the frame level. It appears in the first opcode byte, or in the byte count, of the very next frame after chip select falls. Examples are a program frame that has no write-enable frame before it, or a piece that runs past a page. A wrong status decision shows as a missing or extra 05h frame, and as a `done` that arrives earlier or later than the busy count in the flash model allows. Shifter faults show within one byte, as wrong `rd_data` values or as an `spi_sclk` high time that does not match `cfg_div`.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam int ADDR_W = 24;
  localparam int PAGE_W = 8;
  localparam int PAGE_B = 1 << PAGE_W;

  // user request codes
  localparam logic [3:0] OP_READ  = 4'd0;
  localparam logic [3:0] OP_FAST  = 4'd1;
  localparam logic [3:0] OP_PROG  = 4'd2;
  localparam logic [3:0] OP_E4K   = 4'd3;
  localparam logic [3:0] OP_E32K  = 4'd4;
  localparam logic [3:0] OP_E64K  = 4'd5;
  localparam logic [3:0] OP_CHIP  = 4'd6;
  localparam logic [3:0] OP_ID    = 4'd7;
  localparam logic [3:0] OP_RESET = 4'd8;

  // flash command bytes
  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_STAT  = 8'h05;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_FAST  = 8'h0B;
  localparam logic [7:0] CMD_PROG  = 8'h02;
  localparam logic [7:0] CMD_E4K   = 8'h20;
  localparam logic [7:0] CMD_E32K  = 8'h52;
  localparam logic [7:0] CMD_E64K  = 8'hD8;
  localparam logic [7:0] CMD_CHIP  = 8'hC7;
  localparam logic [7:0] CMD_ID    = 8'h9F;
  localparam logic [7:0] CMD_RSTEN = 8'h66;
  localparam logic [7:0] CMD_RST   = 8'h99;

  typedef enum logic [2:0] {
    PH_WREN, PH_MAIN, PH_POLL, PH_RST1, PH_RST2
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_LOAD, S_XFER, S_END
  } seq_state_e;
endpackage

// File: rtl/nor_spi_shifter.sv
module nor_spi_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             start,
  input  logic [7:0]       tx,
  output logic             done,
  output logic [7:0]       rx,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  logic             active;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      rx     <= '0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          sh     <= tx;
          mosi   <= tx[7];
          bitn   <= '0;
          cnt    <= '0;
        end
      end else if (cnt == div) begin
        cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
            mosi <= sh[6];
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nor_frame_plan.sv
module nor_frame_plan
  import nor_seq_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int ID_BYTES = 3
) (
  input  phase_e            ph,
  input  logic [3:0]        op,
  input  logic [PAGE_W-1:0] page_off,
  input  logic [LEN_W-1:0]  rem,
  output logic [7:0]        opcode,
  output logic [2:0]        hdr_n,
  output logic [LEN_W:0]    data_n,
  output logic [LEN_W:0]    chunk,
  output logic              tx_user,
  output logic              rx_user,
  output logic              is_prog,
  output logic              is_erase
);
  localparam int FL_W = LEN_W + 1;

  logic [FL_W-1:0] space;
  logic [FL_W-1:0] rem_x;

  always_comb begin
    rem_x    = FL_W'(rem);
    space    = FL_W'(PAGE_B) - FL_W'(page_off);
    chunk    = (rem_x < space) ? rem_x : space;
    is_prog  = (op == OP_PROG);
    is_erase = (op == OP_E4K) || (op == OP_E32K) || (op == OP_E64K) || (op == OP_CHIP);
    opcode   = CMD_WREN;
    hdr_n    = 3'd1;
    data_n   = '0;
    tx_user  = 1'b0;
    rx_user  = 1'b0;
    case (ph)
      PH_WREN: opcode = CMD_WREN;
      PH_POLL: begin
        opcode = CMD_STAT;
        data_n = FL_W'(1);
      end
      PH_RST1: opcode = CMD_RSTEN;
      PH_RST2: opcode = CMD_RST;
      default: begin
        case (op)
          OP_READ: begin
            opcode  = CMD_READ;
            hdr_n   = 3'd4;
            data_n  = rem_x;
            rx_user = 1'b1;
          end
          OP_FAST: begin
            opcode  = CMD_FAST;
            hdr_n   = 3'd5;
            data_n  = rem_x;
            rx_user = 1'b1;
          end
          OP_PROG: begin
            opcode  = CMD_PROG;
            hdr_n   = 3'd4;
            data_n  = chunk;
            tx_user = 1'b1;
          end
          OP_E4K: begin
            opcode = CMD_E4K;
            hdr_n  = 3'd4;
          end
          OP_E32K: begin
            opcode = CMD_E32K;
            hdr_n  = 3'd4;
          end
          OP_E64K: begin
            opcode = CMD_E64K;
            hdr_n  = 3'd4;
          end
          OP_CHIP: opcode = CMD_CHIP;
          OP_ID: begin
            opcode  = CMD_ID;
            data_n  = FL_W'(ID_BYTES);
            rx_user = 1'b1;
          end
          default: opcode = CMD_WREN;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int DIV_W    = 8,
  parameter int CS_GAP   = 4,
  parameter int ID_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  output logic              done,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int FL_W  = LEN_W + 1;
  localparam int GAP_W = $clog2(CS_GAP + 1);

  seq_state_e        st;
  phase_e            ph;
  logic [3:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [GAP_W-1:0]  gap_cnt;
  logic [FL_W-1:0]   idx;
  logic              cs_n_q;
  logic              eng_start;
  logic [7:0]        eng_tx;
  logic              eng_done;
  logic [7:0]        eng_rx;
  logic              rd_valid_q;
  logic [7:0]        rd_data_q;
  logic              done_q;
  logic              stat_busy;

  logic [7:0]        opcode;
  logic [2:0]        hdr_n;
  logic [FL_W-1:0]   data_n;
  logic [FL_W-1:0]   chunk;
  logic              tx_user, rx_user, is_prog, is_erase;
  logic [FL_W-1:0]   hdr_x;
  logic [FL_W-1:0]   frame_last;
  logic              in_data;
  logic [7:0]        hdr_byte;

  nor_frame_plan #(.LEN_W(LEN_W), .ID_BYTES(ID_BYTES)) u_plan (
    .ph       (ph),
    .op       (op_q),
    .page_off (addr_q[PAGE_W-1:0]),
    .rem      (rem_q),
    .opcode   (opcode),
    .hdr_n    (hdr_n),
    .data_n   (data_n),
    .chunk    (chunk),
    .tx_user  (tx_user),
    .rx_user  (rx_user),
    .is_prog  (is_prog),
    .is_erase (is_erase)
  );

  nor_spi_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .div   (cfg_div),
    .start (eng_start),
    .tx    (eng_tx),
    .done  (eng_done),
    .rx    (eng_rx),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .miso  (spi_miso)
  );

  always_comb begin
    hdr_x      = FL_W'(hdr_n);
    frame_last = hdr_x + data_n - FL_W'(1);
    in_data    = (idx >= hdr_x);
    case (idx)
      FL_W'(0): hdr_byte = opcode;
      FL_W'(1): hdr_byte = addr_q[23:16];
      FL_W'(2): hdr_byte = addr_q[15:8];
      FL_W'(3): hdr_byte = addr_q[7:0];
      default:  hdr_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ph         <= PH_MAIN;
      op_q       <= '0;
      addr_q     <= '0;
      rem_q      <= '0;
      gap_cnt    <= '0;
      idx        <= '0;
      cs_n_q     <= 1'b1;
      eng_start  <= 1'b0;
      eng_tx     <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      done_q     <= 1'b0;
      stat_busy  <= 1'b0;
    end else begin
      eng_start  <= 1'b0;
      rd_valid_q <= 1'b0;
      done_q     <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            op_q    <= req_op;
            addr_q  <= req_addr;
            rem_q   <= req_len;
            gap_cnt <= '0;
            case (req_op)
              OP_READ, OP_FAST, OP_ID: begin
                ph <= PH_MAIN;
                st <= S_GAP;
              end
              OP_PROG, OP_E4K, OP_E32K, OP_E64K, OP_CHIP: begin
                ph <= PH_WREN;
                st <= S_GAP;
              end
              OP_RESET: begin
                ph <= PH_RST1;
                st <= S_GAP;
              end
              default: done_q <= 1'b1;
            endcase
          end
        end
        S_GAP: begin
          if (gap_cnt == GAP_W'(CS_GAP - 1)) begin
            st     <= S_LOAD;
            idx    <= '0;
            cs_n_q <= 1'b0;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_LOAD: begin
          if (!in_data) begin
            eng_tx    <= hdr_byte;
            eng_start <= 1'b1;
            st        <= S_XFER;
          end else if (!tx_user) begin
            eng_tx    <= 8'h00;
            eng_start <= 1'b1;
            st        <= S_XFER;
          end else if (wr_valid) begin
            eng_tx    <= wr_data;
            eng_start <= 1'b1;
            st        <= S_XFER;
          end
        end
        S_XFER: begin
          if (eng_done) begin
            if (in_data && rx_user) begin
              rd_valid_q <= 1'b1;
              rd_data_q  <= eng_rx;
            end
            if (in_data && ph == PH_POLL) stat_busy <= eng_rx[0];
            if (idx == frame_last) begin
              cs_n_q <= 1'b1;
              st     <= S_END;
            end else begin
              idx <= idx + 1'b1;
              st  <= S_LOAD;
            end
          end
        end
        S_END: begin
          gap_cnt <= '0;
          st      <= S_GAP;
          case (ph)
            PH_WREN: ph <= PH_MAIN;
            PH_MAIN: begin
              if (is_prog) begin
                addr_q <= addr_q + ADDR_W'(chunk);
                rem_q  <= rem_q - LEN_W'(chunk);
                ph     <= PH_POLL;
              end else if (is_erase) begin
                ph <= PH_POLL;
              end else begin
                done_q <= 1'b1;
                st     <= S_IDLE;
              end
            end
            PH_POLL: begin
              if (stat_busy) begin
                ph <= PH_POLL;
              end else if (is_prog && rem_q != '0) begin
                ph <= PH_WREN;
              end else begin
                done_q <= 1'b1;
                st     <= S_IDLE;
              end
            end
            PH_RST1: ph <= PH_RST2;
            default: begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_LOAD) && in_data && tx_user;
  assign done      = done_q;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign spi_cs_n  = cs_n_q;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int CS_GAP = 4
) (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic req_ready,
  input logic done,
  input logic wr_ready
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (!spi_cs_n) hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
  end

  // R1
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (spi_cs_n && !spi_sclk));

  // R2
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  // R2
  mosi_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R11
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> (hi_cnt >= 16'(CS_GAP)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  wr_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> !spi_cs_n);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .spi_cs_n  (spi_cs_n),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .req_ready (req_ready),
  .done      (done),
  .wr_ready  (wr_ready)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
  localparam int LEN_W  = 16;
  localparam int DIV_W  = 8;
  localparam int CS_GAP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DIV_W-1:0] cfg_div = 8'd1;
  logic req_valid = 1'b0;
  logic [3:0] req_op = '0;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready, done, wr_ready, rd_valid;
  logic [7:0] wr_data = '0;
  logic wr_valid = 1'b1;
  logic [7:0] rd_data;
  logic spi_cs_n, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;

  always #5 clk = ~clk;

  nor_cmd_seq #(.LEN_W(LEN_W), .DIV_W(DIV_W), .CS_GAP(CS_GAP), .ID_BYTES(3)) u_dut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .req_ready(req_ready), .done(done),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] fmem [0:1023];
  logic [7:0] fb [0:7];
  logic [7:0] sin, sout;
  int bits = 0, nbytes = 0;
  int busy_left = 0;
  bit wel = 0;
  int wel_bad = 0;
  logic [7:0] f_op [0:63];
  logic [23:0] f_addr [0:63];
  int f_nb [0:63];
  int fc = 0;

  function automatic int out_start(input logic [7:0] c);
    case (c)
      8'h05, 8'h9F: return 1;
      8'h03: return 4;
      8'h0B: return 5;
      default: return 1000;
    endcase
  endfunction

  function automatic logic [7:0] out_byte(input int k);
    logic [7:0] lo;
    lo = fb[3] + 8'(k);
    case (fb[0])
      8'h05: return {6'b0, wel, busy_left > 0};
      8'h9F: return (k % 3 == 0) ? 8'hA5 : (k % 3 == 1) ? 8'h3C : 8'h17;
      default: return fmem[10'({fb[2], fb[3]} + 16'(k))];
    endcase
  endfunction

  always @(negedge spi_cs_n) begin
    bits = 0;
    nbytes = 0;
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sin = {sin[6:0], spi_mosi};
    bits++;
    if (bits % 8 == 0) begin
      if (nbytes < 8) fb[nbytes] = sin;
      if (fb[0] == 8'h02 && nbytes >= 4)
        fmem[{fb[2][1:0], 8'(fb[3] + 8'(nbytes - 4))}] = sin;
      nbytes++;
    end
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    if (bits % 8 == 0 && bits / 8 >= out_start(fb[0])) begin
      sout = out_byte(bits / 8 - out_start(fb[0]));
    end
    spi_miso <= sout[7];
    sout = {sout[6:0], 1'b0};
  end

  always @(posedge spi_cs_n) if (nbytes > 0 && fc < 64) begin
    f_op[fc] = fb[0];
    f_addr[fc] = {fb[1], fb[2], fb[3]};
    f_nb[fc] = nbytes;
    fc++;
    case (fb[0])
      8'h06: wel = 1;
      8'h04: wel = 0;
      8'h02, 8'h20, 8'h52, 8'hD8, 8'hC7: begin
        if (!wel) wel_bad++;
        wel = 0;
        busy_left = 3;
      end
      8'h05: if (busy_left > 0) busy_left--;
      default: ;
    endcase
  end

  // ---------------- port monitor ----------------
  logic [7:0] wsrc [0:511];
  int widx = 0;
  bit take_pend = 0;
  logic [7:0] rbuf [0:63];
  int rcnt = 0;
  bit done_seen = 0;
  int cyc = 0;
  int hi_w = 0, last_hw = 0;
  int cur_hi = 0, min_gap = 1000;

  always @(negedge clk) begin
    cyc++;
    if (take_pend) widx++;
    wr_data = wsrc[widx % 512];
    take_pend = wr_ready && wr_valid;
    if (rd_valid && rcnt < 64) begin
      rbuf[rcnt] = rd_data;
      rcnt++;
    end
    if (done) done_seen = 1;
    if (spi_sclk) hi_w++;
    else if (hi_w > 0) begin
      last_hw = hi_w;
      hi_w = 0;
    end
    if (spi_cs_n) cur_hi++;
    else begin
      if (cur_hi > 0 && cur_hi < min_gap) min_gap = cur_hi;
      cur_hi = 0;
    end
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_req(input logic [3:0] op, input logic [23:0] a, input int len, output int lat);
    @(negedge clk);
    req_op = op;
    req_addr = a;
    req_len = LEN_W'(len);
    req_valid = 1'b1;
    rcnt = 0;
    widx = 0;
    done_seen = 0;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done_seen) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic expect_frame(input int i, input logic [7:0] op, input int nb, input string req);
    check(f_op[i] == op, req, "frame opcode", f_op[i], op);
    check(f_nb[i] == nb, req, "frame length", f_nb[i], nb);
  endtask

  task automatic expect_polls(input int i, input string req);
    for (int k = 0; k < 4; k++) expect_frame(i + k, 8'h05, 2, req);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state;
    check(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R1", "sclk after reset", spi_sclk, 0);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
  endtask

  task automatic t_read;
    int f0, lat;
    bit ok;
    f0 = fc;
    do_req(4'd0, 24'h000010, 6, lat);
    check(fc - f0 == 1, "R3", "frame count", fc - f0, 1);
    expect_frame(f0, 8'h03, 10, "R3");
    check(f_addr[f0] == 24'h000010, "R3", "address bytes", f_addr[f0], 24'h10);
    check(rcnt == 6, "R3", "bytes returned", rcnt, 6);
    ok = 1;
    for (int i = 0; i < 6; i++) if (rbuf[i] != (8'(16 + i) ^ 8'h5A)) ok = 0;
    check(ok, "R3", "read data", rbuf[0], 8'h10 ^ 8'h5A);
    check(last_hw == 2, "R2", "sclk high width div=1", last_hw, 2);
  endtask

  task automatic t_fast;
    int f0, lat;
    bit ok;
    f0 = fc;
    do_req(4'd1, 24'h000203, 4, lat);
    expect_frame(f0, 8'h0B, 9, "R4");
    check(f_addr[f0] == 24'h000203, "R4", "address bytes", f_addr[f0], 24'h203);
    ok = (rcnt == 4);
    for (int i = 0; i < 4; i++) if (rbuf[i] != (8'(8'h03 + i) ^ 8'h5A)) ok = 0;
    check(ok, "R4", "fast read data", rbuf[0], 8'h03 ^ 8'h5A);
  endtask

  task automatic t_prog;
    int f0, lat;
    bit ok;
    int pn[3];
    logic [23:0] pa[3];
    pn = '{16, 256, 28};
    pa = '{24'h0000F0, 24'h000100, 24'h000200};
    for (int i = 0; i < 512; i++) wsrc[i] = 8'(i * 7 + 3);
    f0 = fc;
    do_req(4'd2, 24'h0000F0, 300, lat);
    check(fc - f0 == 18, "R7", "program frame count", fc - f0, 18);
    for (int p = 0; p < 3; p++) begin
      expect_frame(f0 + 6 * p, 8'h06, 1, "R5");
      expect_frame(f0 + 6 * p + 1, 8'h02, 4 + pn[p], "R6");
      check(f_addr[f0 + 6 * p + 1] == pa[p], "R6", "piece address", f_addr[f0 + 6 * p + 1], pa[p]);
      expect_polls(f0 + 6 * p + 2, "R7");
    end
    check(wel_bad == 0, "R5", "program without write enable", wel_bad, 0);
    ok = 1;
    for (int i = 0; i < 300; i++) if (fmem[10'(16'hF0 + 16'(i))] != wsrc[i]) ok = 0;
    check(ok, "R6", "programmed contents", fmem[10'hF0], wsrc[0]);
    f0 = fc;
    do_req(4'd1, 24'h0000FC, 8, lat);
    ok = (rcnt == 8);
    for (int i = 0; i < 8; i++) if (rbuf[i] != wsrc[12 + i]) ok = 0;
    check(ok, "R6", "readback across page", rbuf[0], wsrc[12]);
  endtask

  task automatic t_erase(input logic [3:0] op, input logic [7:0] cmd, input int nb);
    int f0, lat;
    f0 = fc;
    do_req(op, 24'h012345, 1, lat);
    check(fc - f0 == 6, "R8", "erase frame count", fc - f0, 6);
    expect_frame(f0, 8'h06, 1, "R8");
    expect_frame(f0 + 1, cmd, nb, "R8");
    if (nb == 4) check(f_addr[f0 + 1] == 24'h012345, "R8", "erase address", f_addr[f0 + 1], 24'h012345);
    expect_polls(f0 + 2, "R7");
    check(wel_bad == 0, "R8", "erase without write enable", wel_bad, 0);
  endtask

  task automatic t_id;
    int f0, lat;
    cfg_div = 8'd3;
    f0 = fc;
    do_req(4'd7, 24'h0, 1, lat);
    expect_frame(f0, 8'h9F, 4, "R9");
    check(rcnt == 3 && rbuf[0] == 8'hA5 && rbuf[1] == 8'h3C && rbuf[2] == 8'h17,
          "R9", "id bytes", {rbuf[0], rbuf[1], rbuf[2]}, 24'hA53C17);
    check(last_hw == 4, "R2", "sclk high width div=3", last_hw, 4);
    cfg_div = 8'd1;
  endtask

  task automatic t_devreset;
    int f0, lat;
    f0 = fc;
    do_req(4'd8, 24'h0, 1, lat);
    check(fc - f0 == 2, "R10", "reset frame count", fc - f0, 2);
    expect_frame(f0, 8'h66, 1, "R10");
    expect_frame(f0 + 1, 8'h99, 1, "R10");
  endtask

  task automatic t_bad;
    int f0, lat;
    f0 = fc;
    min_gap = min_gap;
    do_req(4'd12, 24'h0, 1, lat);
    check(lat <= 2, "R12", "done latency", lat, 2);
    repeat (20) @(negedge clk);
    check(fc == f0, "R12", "frames for undefined op", fc - f0, 0);
    check(spi_cs_n == 1'b1, "R12", "cs_n stays high", spi_cs_n, 1);
    check(req_ready == 1'b1, "R1", "ready after request", req_ready, 1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) fmem[i] = 8'(i) ^ 8'h5A;
    for (int i = 0; i < 512; i++) wsrc[i] = 8'h00;
    for (int i = 0; i < 8; i++) fb[i] = 8'h00;
    sin = '0;
    sout = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_read();
    t_fast();
    t_prog();
    t_erase(4'd3, 8'h20, 4);
    t_erase(4'd4, 8'h52, 4);
    t_erase(4'd5, 8'hD8, 4);
    t_erase(4'd6, 8'hC7, 1);
    t_id();
    t_devreset();
    t_bad();
    check(min_gap >= CS_GAP, "R11", "minimum cs high gap", min_gap, CS_GAP);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule